// File: doc/BRIEF.md
# Link Group Cell-Slot Enable Generator

This block turns a stream of bit-rate enables into a stream of cell-slot enables for the links of an inverse-multiplexed ATM group. Every lane runs on the system clock. Each system cycle, a lane receives a single-cycle bit tick from one of several selectable sources. The lane emits a one-cycle enable each time a data cell slot falls due. Each group has a receive lane and a transmit lane, and the two are fully independent.

The average ratio is fractional. Each bit tick adds N·P to a lane accumulator, where N is the link count and P is the framing payload factor. A cell slot falls due when the accumulator reaches 424·F, the number of bits in a 53-byte cell scaled by the framing bit factor F. The first slot of every M-slot frame carries the control cell, so it produces no enable. After every 2048 frame slots, one further slot is withheld as the stuff adjustment. A single write port loads the M, N, P, F and source setting of one lane. The write also restarts that lane.

Top module: `ima_cell_rate_div`

## Requirements
- R1: While reset is high, and after it, every cell enable output is low, and no unconfigured lane ever raises its enable.
- R2: For each selected bit tick, the lane adds N·P to its accumulator. When the sum is at least 424·F, a slot falls due and 424·F is subtracted. Otherwise the sum is kept.
- R3: Frame position counts due slots from 0 to M-1 and then wraps. A slot at position 0 is the control slot and produces no enable. The other M-1 positions each produce one enable.
- R4: After 2048 frame slots, the next due slot is a stuff slot. It produces no enable and does not advance the frame position.
- R5: The enable is registered. It is high for exactly the one system cycle after the cycle in which the bit tick completed a data slot.
- R6: A write with cfg_we high loads the lane picked by cfg_grp and cfg_dir (0 = receive, 1 = transmit). The write clears that lane's accumulator, frame position and stuff count, and leaves every other lane unchanged.
- R7: A lane runs only if M ≥ 2, N ≥ 1, P ≥ 1, F ≥ 1 and N·P ≤ 424·F. Any other setting keeps the lane silent until a valid write arrives.
- R8: cfg_src picks which bit_tick input feeds the lane. Ticks on the other inputs have no effect on that lane.
- R9: A bit tick in the same cycle as a write to its lane is discarded.
- R10: Two lanes with the same setting and the same source produce identical enable streams.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | NUM_SRC | Single-cycle bit-rate enables, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_grp | input | GRP_W | Group index of the write |
| cfg_dir | input | 1 | Lane direction of the write: 0 receive, 1 transmit |
| cfg_m | input | 9 | Frame length M in cells |
| cfg_n | input | 6 | Number of links N |
| cfg_p | input | 10 | Framing payload factor P |
| cfg_f | input | 4 | Framing bit factor F |
| cfg_src | input | SRC_W | Bit-tick source for the lane |
| rx_cell_tick | output | NUM_GROUPS | Receive cell-slot enables, one per group |
| tx_cell_tick | output | NUM_GROUPS | Transmit cell-slot enables, one per group |

## Verification
The bench crosses the 2048-slot boundary with a slot on every tick. A design that counted the stuff slot as a frame slot, or that forgot to withhold it, would show an enable in the wrong place around slots 2049 to 2051. It rewrites a lane while a tick is present and while the lane's twin keeps running. A design that honoured the tick, or that cleared more than one lane, would shift the enable pattern. It also feeds a lane from a source it did not select, and loads settings whose N·P exceeds the threshold or whose frame is too short. Either case would produce enables on a lane that must stay silent.

// File: rtl/ima_crd_pkg.sv
package ima_crd_pkg;
  localparam int M_W       = 9;
  localparam int N_W       = 6;
  localparam int P_W       = 10;
  localparam int F_W       = 4;
  localparam int CELL_BITS = 424;
  localparam int STEP_W    = N_W + P_W;
  localparam int THR_W     = $clog2(CELL_BITS * ((1 << F_W) - 1) + 1);
  localparam int ACC_W     = ((STEP_W > THR_W) ? STEP_W : THR_W) + 1;

  typedef enum logic {DIR_RX = 1'b0, DIR_TX = 1'b1} lane_dir_e;

  typedef struct packed {
    logic              valid;
    logic [M_W-1:0]    m;
    logic [STEP_W-1:0] step;
    logic [THR_W-1:0]  thr;
  } lane_par_t;
endpackage

// File: rtl/ima_cfg_decode.sv
module ima_cfg_decode
  import ima_crd_pkg::*;
#(
  parameter int NUM_GROUPS = 16,
  parameter int GRP_W      = 4,
  localparam int LANES     = 2 * NUM_GROUPS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [GRP_W-1:0] cfg_grp,
  input  logic             cfg_dir,
  input  logic [M_W-1:0]   cfg_m,
  input  logic [N_W-1:0]   cfg_n,
  input  logic [P_W-1:0]   cfg_p,
  input  logic [F_W-1:0]   cfg_f,
  output lane_par_t        par,
  output logic [LANES-1:0] load
);
  lane_dir_e         dir;
  logic [STEP_W-1:0] prod;
  logic [THR_W-1:0]  thr;

  assign dir = lane_dir_e'(cfg_dir);

  // one shared multiplier pair on the write path
  always_comb begin
    prod      = STEP_W'(cfg_n) * STEP_W'(cfg_p);
    thr       = THR_W'(CELL_BITS) * THR_W'(cfg_f);
    par.m     = cfg_m;
    par.step  = prod;
    par.thr   = thr;
    par.valid = (cfg_m >= M_W'(2)) && (cfg_n != '0) && (cfg_p != '0) &&
                (cfg_f != '0) && (ACC_W'(prod) <= ACC_W'(thr));
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    assign load[g]              = cfg_we && (dir == DIR_RX) && (cfg_grp == GRP_W'(g));
    assign load[NUM_GROUPS + g] = cfg_we && (dir == DIR_TX) && (cfg_grp == GRP_W'(g));
  end

  AST_ONE_LANE_LOADED: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load)); // R6
  AST_LOAD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    (load != '0) |-> cfg_we); // R6
endmodule

// File: rtl/ima_tick_select.sv
module ima_tick_select #(
  parameter int NUM_SRC = 4,
  parameter int SRC_W   = 2
) (
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SRC_W-1:0]   sel,
  output logic               tick
);
  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SRC_W'(i)) tick = src_tick[i];
    end
  end
endmodule

// File: rtl/ima_slot_acc.sv
module ima_slot_acc
  import ima_crd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  input  logic [THR_W-1:0]  thr,
  output logic              slot
);
  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;

  always_comb begin
    sum  = acc_q + ACC_W'(step);
    slot = en && tick && (sum >= ACC_W'(thr));
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc_q <= '0;
    end else if (en && tick) begin
      acc_q <= slot ? (sum - ACC_W'(thr)) : sum;
    end
  end

  AST_ACC_BELOW_THR: assert property (@(posedge clk) disable iff (rst)
    en |-> (acc_q < ACC_W'(thr))); // R2
  AST_IDLE_HOLDS_ACC: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(acc_q)); // R8
endmodule

// File: rtl/ima_frame_seq.sv
module ima_frame_seq
  import ima_crd_pkg::*;
#(
  parameter int STUFF_CELLS = 2048,
  localparam int SC_W       = $clog2(STUFF_CELLS)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr,
  input  logic           en,
  input  logic           slot,
  input  logic [M_W-1:0] m,
  output logic           cell_tick
);
  logic [M_W-1:0]  pos_q;
  logic [SC_W-1:0] scnt_q;
  logic            pend_q;
  logic            tick_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pos_q  <= '0;
      scnt_q <= '0;
      pend_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (slot) begin
        if (pend_q) begin
          pend_q <= 1'b0;
        end else begin
          tick_q <= (pos_q != '0);
          pos_q  <= (pos_q == m - M_W'(1)) ? '0 : pos_q + M_W'(1);
          if (scnt_q == SC_W'(STUFF_CELLS - 1)) begin
            scnt_q <= '0;
            pend_q <= 1'b1;
          end else begin
            scnt_q <= scnt_q + SC_W'(1);
          end
        end
      end
    end
  end

  assign cell_tick = tick_q;

  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    en |-> (pos_q < m)); // R3
  AST_CONTROL_SLOT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (slot && !pend_q && (pos_q == '0)) |=> !cell_tick); // R3
  AST_STUFF_SLOT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (slot && pend_q) |=> !cell_tick); // R4
  AST_STUFF_KEEPS_POS: assert property (@(posedge clk) disable iff (rst)
    (slot && pend_q && !clr) |=> $stable(pos_q)); // R4
  AST_PULSE_AFTER_SLOT: assert property (@(posedge clk) disable iff (rst)
    cell_tick |-> $past(slot)); // R5
endmodule

// File: rtl/ima_cell_lane.sv
module ima_cell_lane
  import ima_crd_pkg::*;
#(
  parameter int NUM_SRC     = 4,
  parameter int SRC_W       = 2,
  parameter int STUFF_CELLS = 2048
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  lane_par_t          par,
  input  logic [SRC_W-1:0]   src_in,
  input  logic [NUM_SRC-1:0] src_tick,
  output logic               cell_tick
);
  lane_par_t        par_q;
  logic [SRC_W-1:0] src_q;
  logic             en;
  logic             tick;
  logic             slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      par_q <= '0;
      src_q <= '0;
    end else if (load) begin
      par_q <= par;
      src_q <= src_in;
    end
  end

  // a tick arriving with the write is dropped
  assign en = par_q.valid && !load;

  ima_tick_select #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_sel (
    .src_tick (src_tick),
    .sel      (src_q),
    .tick     (tick)
  );

  ima_slot_acc u_acc (
    .clk  (clk),
    .rst  (rst),
    .clr  (load),
    .en   (en),
    .tick (tick),
    .step (par_q.step),
    .thr  (par_q.thr),
    .slot (slot)
  );

  ima_frame_seq #(.STUFF_CELLS(STUFF_CELLS)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .clr       (load),
    .en        (en),
    .slot      (slot),
    .m         (par_q.m),
    .cell_tick (cell_tick)
  );

  AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !par_q.valid |=> !cell_tick); // R7
  AST_LOAD_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    load |=> !cell_tick); // R9
endmodule

// File: rtl/ima_cell_rate_div.sv
module ima_cell_rate_div
  import ima_crd_pkg::*;
#(
  parameter int NUM_GROUPS  = 16,
  parameter int NUM_SRC     = 4,
  parameter int STUFF_CELLS = 2048,
  localparam int GRP_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int SRC_W      = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_SRC-1:0]    bit_tick,
  input  logic                  cfg_we,
  input  logic [GRP_W-1:0]      cfg_grp,
  input  logic                  cfg_dir,
  input  logic [M_W-1:0]        cfg_m,
  input  logic [N_W-1:0]        cfg_n,
  input  logic [P_W-1:0]        cfg_p,
  input  logic [F_W-1:0]        cfg_f,
  input  logic [SRC_W-1:0]      cfg_src,
  output logic [NUM_GROUPS-1:0] rx_cell_tick,
  output logic [NUM_GROUPS-1:0] tx_cell_tick
);
  localparam int LANES = 2 * NUM_GROUPS;

  lane_par_t        par;
  logic [LANES-1:0] load;
  logic [LANES-1:0] lane_tick;

  ima_cfg_decode #(.NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .cfg_we  (cfg_we),
    .cfg_grp (cfg_grp),
    .cfg_dir (cfg_dir),
    .cfg_m   (cfg_m),
    .cfg_n   (cfg_n),
    .cfg_p   (cfg_p),
    .cfg_f   (cfg_f),
    .par     (par),
    .load    (load)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    ima_cell_lane #(
      .NUM_SRC     (NUM_SRC),
      .SRC_W       (SRC_W),
      .STUFF_CELLS (STUFF_CELLS)
    ) u_lane (
      .clk       (clk),
      .rst       (rst),
      .load      (load[l]),
      .par       (par),
      .src_in    (cfg_src),
      .src_tick  (bit_tick),
      .cell_tick (lane_tick[l])
    );
  end

  assign rx_cell_tick = lane_tick[NUM_GROUPS-1:0];
  assign tx_cell_tick = lane_tick[LANES-1:NUM_GROUPS];

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (lane_tick == '0)); // R1
endmodule

// File: tb/tb_ima_cell_rate_div.sv
module tb_ima_cell_rate_div;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 16;
  localparam int NS = 4;
  localparam int NL = 2 * NG;

  logic          clk;
  logic          rst;
  logic [NS-1:0] bit_tick;
  logic          cfg_we;
  logic [3:0]    cfg_grp;
  logic          cfg_dir;
  logic [8:0]    cfg_m;
  logic [5:0]    cfg_n;
  logic [9:0]    cfg_p;
  logic [3:0]    cfg_f;
  logic [1:0]    cfg_src;
  logic [NG-1:0] rx_cell_tick;
  logic [NG-1:0] tx_cell_tick;
  logic [NL-1:0] obs;

  ima_cell_rate_div #(.NUM_GROUPS(NG), .NUM_SRC(NS), .STUFF_CELLS(2048)) dut (
    .clk (clk), .rst (rst), .bit_tick (bit_tick), .cfg_we (cfg_we),
    .cfg_grp (cfg_grp), .cfg_dir (cfg_dir), .cfg_m (cfg_m), .cfg_n (cfg_n),
    .cfg_p (cfg_p), .cfg_f (cfg_f), .cfg_src (cfg_src),
    .rx_cell_tick (rx_cell_tick), .tx_cell_tick (tx_cell_tick)
  );

  assign obs = {tx_cell_tick, rx_cell_tick};

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act %0d exp %0d", tag, act, exp);
    end
  endtask

  // behavioural reference: integer state per lane, updated at each edge
  int            md_m [NL];
  int            md_step [NL];
  int            md_thr [NL];
  int            md_src [NL];
  int            md_acc [NL];
  int            md_pos [NL];
  int            md_scnt [NL];
  bit            md_en [NL];
  bit            md_pend [NL];
  logic [NL-1:0] exp_vec;

  always @(posedge clk) begin
    if (rst) begin
      exp_vec = '0;
      for (int l = 0; l < NL; l++) begin
        md_en[l] = 0; md_pend[l] = 0; md_acc[l] = 0; md_pos[l] = 0;
        md_scnt[l] = 0; md_m[l] = 0; md_step[l] = 0; md_thr[l] = 0; md_src[l] = 0;
      end
    end else begin
      for (int l = 0; l < NL; l++) begin
        exp_vec[l] = 1'b0;
        if (cfg_we && int'(cfg_grp) == (l % NG) && int'(cfg_dir) == (l / NG)) begin
          md_m[l]    = int'(cfg_m);
          md_step[l] = int'(cfg_n) * int'(cfg_p);
          md_thr[l]  = 424 * int'(cfg_f);
          md_src[l]  = int'(cfg_src);
          md_en[l]   = (md_m[l] >= 2) && (cfg_n != 0) && (cfg_p != 0) &&
                       (cfg_f != 0) && (md_step[l] <= md_thr[l]);
          md_acc[l] = 0; md_pos[l] = 0; md_scnt[l] = 0; md_pend[l] = 0;
        end else if (md_en[l] && bit_tick[md_src[l]]) begin
          md_acc[l] += md_step[l];
          if (md_acc[l] >= md_thr[l]) begin
            md_acc[l] -= md_thr[l];
            if (md_pend[l]) begin
              md_pend[l] = 0;
            end else begin
              exp_vec[l] = (md_pos[l] != 0);
              md_pos[l]  = (md_pos[l] + 1) % md_m[l];
              md_scnt[l]++;
              if (md_scnt[l] == 2048) begin
                md_scnt[l] = 0;
                md_pend[l] = 1;
              end
            end
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      n_checks++;
      if (obs !== exp_vec) begin
        n_fail++;
        $display("FAIL R2/R3/R4/R6 model compare act %h exp %h", obs, exp_vec);
      end
    end
  end

  // all tasks start and end just after a falling edge
  task automatic write_lane(input int grp, input bit dir, input int m, input int n,
                            input int p, input int f, input int src);
    cfg_grp = grp[3:0]; cfg_dir = dir; cfg_m = m[8:0]; cfg_n = n[5:0];
    cfg_p = p[9:0]; cfg_f = f[3:0]; cfg_src = src[1:0]; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_ticks(input int src, input int n, input int lane, output int cnt);
    cnt = 0;
    bit_tick[src] = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cnt += int'(obs[lane]);
    end
    bit_tick[src] = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog act running exp finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    int c, c2, s;
    logic [4:0] seq;
    rst = 1'b1; bit_tick = '0; cfg_we = 1'b0; cfg_grp = '0; cfg_dir = 1'b0;
    cfg_m = '0; cfg_n = '0; cfg_p = '0; cfg_f = '0; cfg_src = '0;
    repeat (3) @(negedge clk);
    check(obs == '0, "R1 outputs in reset", int'($countones(obs)), 0);
    rst = 1'b0;

    // R1: unconfigured lanes stay silent
    bit_tick = '1;
    c = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      c += $countones(obs);
    end
    bit_tick = '0;
    check(c == 0, "R1 unconfigured pulses", c, 0);

    // R2 R3: step 212, threshold 424 -> slot every 2 ticks, M=4
    write_lane(0, 1'b0, 4, 1, 212, 1, 0);
    run_ticks(0, 800, 0, c);
    check(c == 300, "R2 fractional ratio count", c, 300);

    // R8: lane fed from source 1 ignores source 0
    write_lane(1, 1'b0, 4, 1, 424, 1, 1);
    run_ticks(0, 100, 1, c);
    check(c == 0, "R8 unselected source ignored", c, 0);
    run_ticks(1, 8, 1, c);
    check(c == 6, "R8 selected source M=4 pulses", c, 6);

    // R7: invalid settings stay silent
    write_lane(2, 1'b0, 4, 2, 300, 1, 0);
    write_lane(2, 1'b1, 1, 1, 100, 1, 0);
    bit_tick = '1;
    c = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      c += int'(obs[2]) + int'(obs[NG + 2]);
    end
    bit_tick = '0;
    check(c == 0, "R7 invalid lanes silent", c, 0);

    // R5 R3: single-cycle registered enable
    write_lane(3, 1'b1, 2, 1, 424, 1, 2);
    run_ticks(2, 1, NG + 3, c);
    check(c == 0, "R3 control slot silent", c, 0);
    bit_tick[2] = 1'b1;
    @(negedge clk);
    bit_tick[2] = 1'b0;
    s = int'(obs[NG + 3]);
    check(s == 1, "R5 pulse in next cycle", s, 1);
    @(negedge clk);
    s = int'(obs[NG + 3]);
    check(s == 0, "R5 pulse one cycle wide", s, 0);

    // R4: slot every tick, M=2, across the 2048 boundary
    write_lane(4, 1'b0, 2, 1, 424, 1, 3);
    c = 0;
    bit_tick[3] = 1'b1;
    for (int i = 1; i <= 2051; i++) begin
      @(negedge clk);
      s = int'(obs[4]);
      c += s;
      if (i == 2048) check(s == 1, "R4 last frame slot before stuff", s, 1);
      if (i == 2049) check(s == 0, "R4 stuff slot silent", s, 0);
      if (i == 2050) check(s == 0, "R4 frame position held (control)", s, 0);
      if (i == 2051) check(s == 1, "R4 data slot after stuff", s, 1);
    end
    bit_tick[3] = 1'b0;
    check(c == 1025, "R4 pulse total over 2051 slots", c, 1025);

    // R9: tick coinciding with the write is dropped
    bit_tick[0] = 1'b1;
    write_lane(0, 1'b0, 4, 1, 424, 1, 0);
    s = int'(obs[0]);
    check(s == 0, "R9 quiet in write cycle", s, 0);
    seq = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      seq = {seq[3:0], obs[0]};
    end
    bit_tick[0] = 1'b0;
    check(seq == 5'b01110, "R9 pattern after write", int'(seq), 14);

    // R10 then R6: twin lanes, then restart only one
    write_lane(5, 1'b0, 3, 1, 424, 1, 3);
    write_lane(5, 1'b1, 3, 1, 424, 1, 3);
    c = 0; c2 = 0;
    bit_tick[3] = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      c += int'(obs[5]); c2 += int'(obs[NG + 5]);
    end
    bit_tick[3] = 1'b0;
    check(c == 6, "R10 rx twin count", c, 6);
    check(c2 == 6, "R10 tx twin count", c2, 6);
    write_lane(5, 1'b1, 3, 1, 424, 1, 3);
    c = 0; c2 = 0;
    bit_tick[3] = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      c += int'(obs[5]); c2 += int'(obs[NG + 5]);
    end
    bit_tick[3] = 1'b0;
    check(c == 2, "R6 untouched lane continues", c, 2);
    check(c2 == 1, "R6 rewritten lane restarts", c2, 1);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule